// File: doc/BRIEF.md
# Multi-Wide In-Order Retirement Controller

This block sits at the head of a reorder buffer and decides, every cycle, how many of the oldest micro-ops become architecturally visible. It retires a contiguous group of up to N completed entries in program order. When it retires them, it advances the head pointer and raises one strobe per retiring slot, so that register and memory state can be updated. Dispatch allocates entries at the tail, one group at a time. Execution units report completion, with an optional fault code, against an entry tag. A branch unit reports a mispredict against the tag of the branch.

A fault reported at execute is only recorded in its entry. It becomes a trap only when every older entry has retired and the faulting entry is the first one the scan cannot retire. The pipeline is then flushed and the handler is requested. A mispredict truncates the buffer behind the branch, so faults recorded on the wrong path are discarded and never trap.

Instructions made of several micro-ops are marked by a last-uop bit. Such a flow does not begin retiring until all of its uops are complete, and once it has started, an external interrupt waits until its last uop has retired. An interrupt is taken at such a boundary by flushing everything not yet retired. It wins over a fault that reaches the head in the same cycle only if the request was already present in the cycle before.

Top module: `rob_retire_ctrl`

## Requirements
- R1: Entries retire strictly oldest-first as a contiguous group starting at the head. An entry that is not complete stops the group, even when younger entries are complete.
- R2: At most N entries retire per cycle. `retire_valid` has its low `retire_count` bits set, slot i carries tag `retire_head`+i, and `retire_head` advances by `retire_count` on the next cycle.
- R3: A completion reported with a fault does not trap by itself. When the faulting entry is the first entry the scan reaches that cannot retire, in the same cycle the older entries of the group retire, the faulting entry does not retire, `flush_valid` is high with `flush_cause`=1, `trap_valid` is high with `trap_code` equal to the reported code, and the buffer is empty on the next cycle.
- R4: A mispredict on tag T discards every entry younger than T in the same cycle (`flush_cause`=3, `trap_valid` low), and `alloc_tag` becomes T+1. Faults recorded on discarded entries never trap. A mispredict is reported no later than the completion of its branch.
- R5: At most one entry with the branch bit set retires per cycle, and the group stops at a second branch.
- R6: An entry whose `alloc_fend` bit is 0 belongs to a flow that ends at the next entry with the bit set. An entry that opens a flow may retire only when every uop up to and including that flow's last uop is complete.
- R7: With `irq_req` high, the interrupt is taken only in a cycle where the retired group ends on a flow boundary (or nothing is mid-flow). Then `flush_cause`=2 and `trap_valid` are high, the group of that cycle retires, and all remaining entries are discarded.
- R8: When an interrupt boundary and a fault at the head coincide, the interrupt wins (cause 2) if `irq_req` was high in the previous cycle; otherwise the fault wins (cause 1).
- R9: `alloc_ready` is high exactly when the number of free entries is at least ALLOC_W. An allocation of `alloc_count` entries at `alloc_tag` is accepted only when `alloc_ready` is high and `flush_valid` is low; otherwise it is ignored and `alloc_tag` is unchanged.
- R10: After reset the buffer is empty, nothing retires, no flush is signalled, `alloc_ready` is 1 and `alloc_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_count | input | $clog2(ALLOC_W+1) | Number of entries dispatched this cycle |
| alloc_branch | input | ALLOC_W | Per-slot branch bit of the dispatched entries |
| alloc_fend | input | ALLOC_W | Per-slot last-uop-of-flow bit |
| alloc_ready | output | 1 | At least ALLOC_W entries are free |
| alloc_tag | output | $clog2(DEPTH) | Tag given to dispatch slot 0; slot i gets tag+i |
| cmpl_valid | input | CPORTS | Completion strobe per port |
| cmpl_tag | input | CPORTS*$clog2(DEPTH) | Completed entry tag per port |
| cmpl_fault | input | CPORTS | Completion carries a fault |
| cmpl_code | input | CPORTS*CODE_W | Fault code per port |
| mispredict_valid | input | 1 | Branch mispredict resolved |
| mispredict_tag | input | $clog2(DEPTH) | Tag of the mispredicted branch |
| irq_req | input | 1 | External interrupt request, level |
| retire_valid | output | N | Per-slot retire strobe |
| retire_count | output | $clog2(N+1) | Entries retired this cycle |
| retire_head | output | $clog2(DEPTH) | Tag of the oldest entry (slot 0) |
| flush_valid | output | 1 | Pipeline flush this cycle |
| flush_cause | output | 2 | 1 fault, 2 interrupt, 3 mispredict |
| trap_valid | output | 1 | Handler entry requested (fault or interrupt) |
| trap_code | output | CODE_W | Fault code of a fault trap, else 0 |

## Verification
The assertions watch, every cycle, the relations between the head, the tail and the flush outputs. The head moves by exactly the retired count, a fault or interrupt flush leaves the buffer empty, no group carries two branches, an interrupt flush only appears while the request is high, and a full buffer keeps its tail still. Whether retirement waits for an unfinished older entry or for a whole flow, where a deferred interrupt finally lands, how a fault and an interrupt arriving together are ordered, and that wrong-path faults vanish, can only be shown by the bench's scenarios against its queue model.

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl #(
  parameter int DEPTH   = 16,
  parameter int N       = 4,
  parameter int ALLOC_W = 2,
  parameter int CPORTS  = 2,
  parameter int CODE_W  = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(N+1),
  localparam int AW = $clog2(ALLOC_W+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          alloc_count,
  input  logic [ALLOC_W-1:0]     alloc_branch,
  input  logic [ALLOC_W-1:0]     alloc_fend,
  output logic                   alloc_ready,
  output logic [IW-1:0]          alloc_tag,
  input  logic [CPORTS-1:0]      cmpl_valid,
  input  logic [CPORTS*IW-1:0]   cmpl_tag,
  input  logic [CPORTS-1:0]      cmpl_fault,
  input  logic [CPORTS*CODE_W-1:0] cmpl_code,
  input  logic                   mispredict_valid,
  input  logic [IW-1:0]          mispredict_tag,
  input  logic                   irq_req,
  output logic [N-1:0]           retire_valid,
  output logic [CW-1:0]          retire_count,
  output logic [IW-1:0]          retire_head,
  output logic                   flush_valid,
  output logic [1:0]             flush_cause,
  output logic                   trap_valid,
  output logic [CODE_W-1:0]      trap_code
);

  logic [DEPTH-1:0]  e_done, e_fault, e_br, e_fend;
  logic [CODE_W-1:0] e_code [DEPTH];
  logic [IW-1:0]     head;
  logic [IW:0]       cnt;
  logic              mid_flow, irq_q;

  logic [IW-1:0]     slot_idx [DEPTH];
  logic [DEPTH-1:0]  o_done, o_fault, o_br, o_fend;
  logic [DEPTH:0]    flow_ok;

  logic [CW-1:0]     ret;
  logic [N-1:0]      ret_br;
  logic              at_bound, fault_ev;
  logic [CODE_W-1:0] fault_code;
  logic              take_irq, take_fault, full_flush, alloc_go;
  logic [IW-1:0]     mp_off;

  for (genvar k = 0; k < DEPTH; k++) begin : g_view
    assign slot_idx[k] = head + IW'(k);
    assign o_done[k]   = ((IW+1)'(k) < cnt) && e_done[slot_idx[k]];
    assign o_fault[k]  = e_fault[slot_idx[k]];
    assign o_br[k]     = e_br[slot_idx[k]];
    assign o_fend[k]   = e_fend[slot_idx[k]];
  end

  always_comb begin
    flow_ok[DEPTH] = 1'b0;
    for (int k = DEPTH-1; k >= 0; k--)
      flow_ok[k] = o_done[k] & (o_fend[k] | flow_ok[k+1]);
  end

  always_comb begin
    logic stop, br_seen;
    ret        = '0;
    ret_br     = '0;
    at_bound   = !mid_flow;
    fault_ev   = 1'b0;
    fault_code = '0;
    stop       = 1'b0;
    br_seen    = 1'b0;
    for (int s = 0; s < N; s++) begin
      if (!stop) begin
        if (!o_done[s]) begin
          stop = 1'b1;
        end else if (o_fault[s]) begin
          stop       = 1'b1;
          fault_ev   = 1'b1;
          fault_code = e_code[slot_idx[s]];
        end else if (at_bound && !flow_ok[s]) begin
          stop = 1'b1;
        end else if (o_br[s] && br_seen) begin
          stop = 1'b1;
        end else begin
          ret       = ret + CW'(1);
          ret_br[s] = o_br[s];
          br_seen   = br_seen | o_br[s];
          at_bound  = o_fend[s];
        end
      end
    end
  end

  assign take_irq   = irq_req && at_bound && (!fault_ev || irq_q);
  assign take_fault = fault_ev && !take_irq;
  assign full_flush = take_irq || take_fault;

  assign flush_valid = full_flush || mispredict_valid;
  assign flush_cause = take_fault ? 2'd1 : take_irq ? 2'd2 : mispredict_valid ? 2'd3 : 2'd0;
  assign trap_valid  = full_flush;
  assign trap_code   = take_fault ? fault_code : '0;

  for (genvar i = 0; i < N; i++) begin : g_rv
    assign retire_valid[i] = (CW'(i) < ret);
  end
  assign retire_count = ret;
  assign retire_head  = head;

  assign alloc_ready = (int'(cnt) + ALLOC_W) <= DEPTH;
  assign alloc_tag   = head + cnt[IW-1:0];
  assign alloc_go    = (alloc_count != '0) && alloc_ready && !flush_valid;
  assign mp_off      = mispredict_tag - head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      cnt      <= '0;
      mid_flow <= 1'b0;
      irq_q    <= 1'b0;
      e_done   <= '0;
      e_fault  <= '0;
      e_br     <= '0;
      e_fend   <= '0;
    end else begin
      irq_q <= irq_req;
      head  <= head + IW'(ret);
      if (full_flush) begin
        cnt      <= '0;
        mid_flow <= 1'b0;
      end else begin
        mid_flow <= !at_bound;
        if (mispredict_valid)
          cnt <= {1'b0, mp_off} + (IW+1)'(1) - (IW+1)'(ret);
        else
          cnt <= cnt - (IW+1)'(ret) + (alloc_go ? (IW+1)'(alloc_count) : '0);
      end
      for (int p = 0; p < CPORTS; p++) begin
        if (cmpl_valid[p] &&
            ({1'b0, cmpl_tag[p*IW +: IW] - head} < cnt)) begin
          e_done[cmpl_tag[p*IW +: IW]]  <= 1'b1;
          e_fault[cmpl_tag[p*IW +: IW]] <= cmpl_fault[p];
          e_code[cmpl_tag[p*IW +: IW]]  <= cmpl_code[p*CODE_W +: CODE_W];
        end
      end
      for (int i = 0; i < ALLOC_W; i++) begin
        if (alloc_go && (i < int'(alloc_count))) begin
          e_done[alloc_tag + IW'(i)]  <= 1'b0;
          e_fault[alloc_tag + IW'(i)] <= 1'b0;
          e_br[alloc_tag + IW'(i)]    <= alloc_branch[i];
          e_fend[alloc_tag + IW'(i)]  <= alloc_fend[i];
        end
      end
    end
  end

endmodule

module rob_retire_chk #(
  parameter int N  = 4,
  parameter int IW = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] retire_count,
  input logic [N-1:0]  retire_valid,
  input logic [IW-1:0] retire_head,
  input logic [IW-1:0] alloc_tag,
  input logic          alloc_ready,
  input logic          flush_valid,
  input logic [1:0]    flush_cause,
  input logic          trap_valid,
  input logic          irq_req,
  input logic [N-1:0]  ret_br
);

  assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (retire_head == $past(retire_head) + IW'($past(retire_count))));

  assert_empty_after_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && (flush_cause == 2'd1 || flush_cause == 2'd2)) |=> (alloc_tag == retire_head));

  assert_trap_flushes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (flush_valid && flush_cause != 2'd3));

  assert_one_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ret_br & retire_valid) <= 1);

  assert_irq_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_cause == 2'd2) |-> irq_req);

  assert_full_holds_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush_valid) |=> $stable(alloc_tag));

endmodule

bind rob_retire_ctrl rob_retire_chk #(.N(N), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_count(retire_count), .retire_valid(retire_valid),
  .retire_head(retire_head), .alloc_tag(alloc_tag), .alloc_ready(alloc_ready),
  .flush_valid(flush_valid), .flush_cause(flush_cause), .trap_valid(trap_valid),
  .irq_req(irq_req), .ret_br(ret_br)
);

// File: tb/rob_retire_ctrl_bench.sv
`timescale 1ns/1ps
module rob_retire_ctrl_bench;
  localparam int DEPTH = 16, N = 4, ALW = 2, CP = 2, CODE_W = 4;
  localparam int IW = 4, CW = 3, AW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] alloc_count;
  logic [ALW-1:0] alloc_branch, alloc_fend;
  logic alloc_ready;
  logic [IW-1:0] alloc_tag;
  logic [CP-1:0] cmpl_valid, cmpl_fault;
  logic [CP*IW-1:0] cmpl_tag;
  logic [CP*CODE_W-1:0] cmpl_code;
  logic mispredict_valid;
  logic [IW-1:0] mispredict_tag;
  logic irq_req;
  logic [N-1:0] retire_valid;
  logic [CW-1:0] retire_count;
  logic [IW-1:0] retire_head;
  logic flush_valid, trap_valid;
  logic [1:0] flush_cause;
  logic [CODE_W-1:0] trap_code;

  rob_retire_ctrl u_rob_retire_ctrl (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // stimulus staged for the next cycle
  int s_acnt; logic [1:0] s_abr, s_afe;
  logic [1:0] s_cv, s_cf; int s_ctag [2]; int s_ccode [2];
  logic s_mp; int s_mptag; logic irq;

  // reference model
  int m_q[$];
  bit m_done [DEPTH], m_flt [DEPTH], m_br [DEPTH], m_fe [DEPTH];
  int m_code [DEPTH];
  int m_head; bit m_mid, m_irq_q;

  int e_ret, e_cause, e_code; bit e_ready, e_ti, e_tf, e_pend;
  int cap_ret, cap_cause, cap_code, cap_head, cap_tag; bit cap_ready;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int c; bit fev, brs, pend, ok; int fcode;
    c = 0; fev = 0; brs = 0; pend = !m_mid; fcode = 0;
    for (int s = 0; s < N; s++) begin
      int t;
      if (s >= m_q.size()) break;
      t = m_q[s];
      if (!m_done[t]) break;
      if (m_flt[t]) begin fev = 1; fcode = m_code[t]; break; end
      if (pend) begin
        ok = 0;
        for (int j = s; j < m_q.size(); j++) begin
          if (!m_done[m_q[j]]) break;
          if (m_fe[m_q[j]]) begin ok = 1; break; end
        end
        if (!ok) break;
      end
      if (m_br[t] && brs) break;
      brs = brs | m_br[t];
      c++;
      pend = m_fe[t];
    end
    e_ret = c; e_pend = pend;
    e_ti = irq && pend && (!fev || m_irq_q);
    e_tf = fev && !e_ti;
    e_cause = e_tf ? 1 : e_ti ? 2 : s_mp ? 3 : 0;
    e_code = e_tf ? fcode : 0;
    e_ready = (DEPTH - m_q.size()) >= ALW;
  endtask

  task automatic model_update();
    bit acc;
    acc = (s_acnt != 0) && e_ready && (e_cause == 0);
    for (int p = 0; p < CP; p++) begin
      if (s_cv[p]) begin
        foreach (m_q[i]) if (m_q[i] == s_ctag[p]) begin
          m_done[s_ctag[p]] = 1; m_flt[s_ctag[p]] = s_cf[p]; m_code[s_ctag[p]] = s_ccode[p];
        end
      end
    end
    repeat (e_ret) void'(m_q.pop_front());
    m_head = (m_head + e_ret) % DEPTH;
    if (e_ti || e_tf) begin
      m_q.delete(); m_mid = 0;
    end else begin
      m_mid = !e_pend;
      if (s_mp) begin
        int off;
        off = (s_mptag - m_head + DEPTH) % DEPTH;
        while (m_q.size() > off + 1) void'(m_q.pop_back());
      end else if (acc) begin
        for (int i = 0; i < s_acnt; i++) begin
          int t;
          t = (m_head + m_q.size()) % DEPTH;
          m_done[t] = 0; m_flt[t] = 0; m_br[t] = s_abr[i]; m_fe[t] = s_afe[i];
          m_q.push_back(t);
        end
      end
    end
    m_irq_q = irq;
  endtask

  task automatic cycle();
    @(negedge clk);
    alloc_count = AW'(s_acnt); alloc_branch = s_abr; alloc_fend = s_afe;
    cmpl_valid = s_cv; cmpl_fault = s_cf;
    cmpl_tag = {IW'(s_ctag[1]), IW'(s_ctag[0])};
    cmpl_code = {CODE_W'(s_ccode[1]), CODE_W'(s_ccode[0])};
    mispredict_valid = s_mp; mispredict_tag = IW'(s_mptag); irq_req = irq;
    #1;
    model_eval();
    chk("R1", "retire_count", int'(retire_count), e_ret);
    chk("R2", "retire_valid", int'(retire_valid), (1 << e_ret) - 1);
    chk("R2", "retire_head", int'(retire_head), m_head);
    chk("R3", "flush_cause", int'(flush_cause), e_cause);
    chk("R3", "flush_valid", int'(flush_valid), int'(e_cause != 0));
    chk("R7", "trap_valid", int'(trap_valid), int'(e_ti || e_tf));
    chk("R3", "trap_code", int'(trap_code), e_code);
    chk("R9", "alloc_ready", int'(alloc_ready), int'(e_ready));
    chk("R9", "alloc_tag", int'(alloc_tag), (m_head + m_q.size()) % DEPTH);
    cap_ret = retire_count; cap_cause = flush_cause; cap_code = trap_code;
    cap_head = retire_head; cap_tag = alloc_tag; cap_ready = alloc_ready;
    @(posedge clk);
    model_update();
    s_acnt = 0; s_abr = 0; s_afe = 0; s_cv = 0; s_cf = 0; s_mp = 0;
  endtask

  task automatic idle(); cycle(); endtask
  task automatic alloc(int n, logic [1:0] br, logic [1:0] fe);
    s_acnt = n; s_abr = br; s_afe = fe; cycle();
  endtask
  task automatic cmpl(int t0, bit f0, int c0, int t1 = -1, bit f1 = 0, int c1 = 0);
    s_cv = 2'b01; s_ctag[0] = t0 % DEPTH; s_cf[0] = f0; s_ccode[0] = c0;
    if (t1 >= 0) begin s_cv[1] = 1; s_ctag[1] = t1 % DEPTH; s_cf[1] = f1; s_ccode[1] = c1; end
    cycle();
  endtask
  function automatic int tl();
    return (m_head + m_q.size()) % DEPTH;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int b, saved;
    s_acnt = 0; s_abr = 0; s_afe = 0; s_cv = 0; s_cf = 0; s_mp = 0; s_mptag = 0; irq = 0;
    s_ctag[0] = 0; s_ctag[1] = 0; s_ccode[0] = 0; s_ccode[1] = 0;
    m_head = 0; m_mid = 0; m_irq_q = 0;
    alloc_count = 0; alloc_branch = 0; alloc_fend = 0; cmpl_valid = 0; cmpl_fault = 0;
    cmpl_tag = 0; cmpl_code = 0; mispredict_valid = 0; mispredict_tag = 0; irq_req = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R10 reset state
    idle();
    chk("R10", "reset retire", cap_ret, 0);
    chk("R10", "reset ready", int'(cap_ready), 1);
    chk("R10", "reset tail", cap_tag, 0);
    chk("R10", "reset flush", cap_cause, 0);

    // R1 / R2: in-order wait, width cap
    b = tl();
    repeat (4) alloc(2, 2'b00, 2'b11);
    cmpl(b+3, 0, 0);
    idle(); chk("R1", "young done old pending", cap_ret, 0);
    cmpl(b+1, 0, 0, b+2, 0, 0);
    idle(); chk("R1", "head still pending", cap_ret, 0);
    cmpl(b+4, 0, 0, b+5, 0, 0);
    cmpl(b+6, 0, 0, b+7, 0, 0);
    cmpl(b, 0, 0);
    idle(); chk("R2", "width cap", cap_ret, N);
    idle(); chk("R2", "second group", cap_ret, N);
    chk("R2", "head advanced", cap_head, (b + 4) % DEPTH);

    // R5: one branch per cycle
    b = tl();
    repeat (2) alloc(2, 2'b11, 2'b11);
    cmpl(b, 0, 0, b+1, 0, 0);
    cmpl(b+2, 0, 0, b+3, 0, 0);
    repeat (3) begin idle(); chk("R5", "branch cap", cap_ret, 1); end

    // R3: deferred fault
    b = tl();
    repeat (2) alloc(2, 2'b00, 2'b11);
    cmpl(b+2, 1, 5, b+3, 0, 0);
    idle(); chk("R3", "fault not yet oldest", cap_cause, 0);
    cmpl(b, 0, 0, b+1, 0, 0);
    idle();
    chk("R3", "older retire", cap_ret, 2);
    chk("R3", "fault cause", cap_cause, 1);
    chk("R3", "fault code", cap_code, 5);
    idle(); chk("R3", "empty after trap", cap_tag, cap_head);

    // R4: mispredict drops wrong-path fault
    b = tl();
    alloc(2, 2'b01, 2'b11);
    alloc(2, 2'b00, 2'b11);
    cmpl(b+2, 1, 7, b+1, 0, 0);
    s_mp = 1; s_mptag = b % DEPTH; cycle();
    chk("R4", "mispredict cause", cap_cause, 3);
    idle(); chk("R4", "tail after mispredict", cap_tag, (b + 1) % DEPTH);
    cmpl(b, 0, 0);
    idle(); chk("R4", "branch retires", cap_ret, 1);
    chk("R4", "no wrong-path trap", cap_cause, 0);
    idle(); chk("R4", "still no trap", cap_cause, 0);

    // R6 / R7: flow gating and deferred interrupt
    b = tl();
    alloc(2, 2'b00, 2'b00);
    alloc(2, 2'b00, 2'b00);
    alloc(2, 2'b00, 2'b10);
    cmpl(b, 0, 0, b+1, 0, 0);
    cmpl(b+2, 0, 0, b+3, 0, 0);
    cmpl(b+4, 0, 0);
    idle(); chk("R6", "flow incomplete", cap_ret, 0);
    cmpl(b+5, 0, 0);
    irq = 1;
    idle(); chk("R6", "flow starts", cap_ret, 4);
    chk("R7", "irq deferred mid-flow", cap_cause, 0);
    idle(); chk("R7", "flow tail", cap_ret, 2);
    chk("R7", "irq at boundary", cap_cause, 2);
    irq = 0;
    idle();

    // R8: interrupt pending earlier beats fault
    b = tl();
    alloc(2, 2'b00, 2'b00);
    alloc(2, 2'b00, 2'b00);
    alloc(2, 2'b00, 2'b10);
    alloc(2, 2'b00, 2'b11);
    cmpl(b, 0, 0, b+1, 0, 0);
    cmpl(b+2, 0, 0, b+3, 0, 0);
    cmpl(b+4, 0, 0, b+6, 1, 3);
    cmpl(b+5, 0, 0);
    irq = 1;
    idle(); chk("R7", "first part of flow", cap_ret, 4);
    idle(); chk("R8", "older irq wins", cap_cause, 2);
    irq = 0;
    idle();

    // R8: fresh interrupt loses to fault
    b = tl();
    alloc(2, 2'b00, 2'b11);
    cmpl(b+1, 1, 6);
    cmpl(b, 0, 0);
    irq = 1;
    idle(); chk("R8", "fault wins new irq", cap_cause, 1);
    chk("R8", "fault code kept", cap_code, 6);
    idle(); chk("R8", "irq taken next", cap_cause, 2);
    irq = 0;

    // R9: allocation stall when nearly full
    b = tl();
    repeat (7) alloc(2, 2'b00, 2'b11);
    alloc(1, 2'b00, 2'b01);
    idle(); chk("R9", "ready low at 15", int'(cap_ready), 0);
    saved = cap_tag;
    alloc(2, 2'b00, 2'b11);
    idle(); chk("R9", "rejected alloc", cap_tag, saved);
    cmpl(b, 0, 0);
    idle(); chk("R9", "one retire", cap_ret, 1);
    idle(); chk("R9", "ready again", int'(cap_ready), 1);
    for (int k = 1; k < 15; k += 2) cmpl(b+k, 0, 0, b+k+1, 0, 0);
    repeat (6) idle();
    chk("R9", "drained", cap_tag, cap_head);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule